// File: doc/BRIEF.md
# Video Controller CPU Register Port

This block is the processor-facing side of a tile-based video controller. A CPU sees eight byte-wide registers that repeat every eight bytes across the 0x2000–0x3FFF window. Through them it sets a control byte and a mask byte, positions a pointer into a 256-byte sprite memory, and builds a 15-bit temporary video address through two-part writes to the scroll and address registers. A data register then reaches the video memory at the current address, stepping by 1 or 32 after each access.

Data-register reads are buffered. A read returns the byte fetched by the previous read. The same read sends a one-cycle fetch request to video memory, and the returned byte refills the buffer. The scroll and address registers share one first/second write toggle, and a status read clears it. The video memory and the sprite memory live outside this block. It drives their address and strobe lines and takes in their read data.

Top module: `vid_reg_port`

## Requirements
- R1: An access is decoded only when cpu_addr[15:13] is 3'b001. Within that window the register index is cpu_addr[2:0] (0 control, 1 mask, 2 status, 3 sprite pointer, 4 sprite data, 5 scroll, 6 address, 7 data), so every register repeats every 8 bytes. Outside the window an access changes no state, raises no strobe and reads as 0.
- R2: A write to register 0 stores the byte in ctrl_o and copies its bits [1:0] into temporary-address bits [11:10]. Bit 2 of the stored byte sets the data-register step to 32 when 1 and to 1 when 0.
- R3: A write to register 1 stores the byte in mask_o.
- R4: With the toggle clear, a scroll write puts data[7:3] into temporary bits [4:0]. With the toggle set, it puts data[7:3] into bits [9:5] and data[2:0] into bits [14:12].
- R5: With the toggle clear, an address write puts data[5:0] into temporary bits [13:8] and clears bit 14. With the toggle set, it puts the byte into bits [7:0] and loads the resulting full temporary value into the current address.
- R6: Every scroll or address write flips the shared toggle. A read of register 2 returns stat_in and clears the toggle. A write to register 2 has no effect.
- R7: A read of register 7 returns the buffer and raises vram_rd for that cycle with vram_addr equal to current address bits [13:0]. The byte on vram_rdata in the following cycle becomes the new buffer. The current address then advances by the step, wrapping at 15 bits.
- R8: A write to register 7 raises vram_wr for that cycle, with vram_addr equal to current address bits [13:0] and vram_wdata equal to the written byte. The current address then advances by the step. vram_rd and vram_wr are never high together.
- R9: A write to register 3 sets the sprite pointer. A read of register 4 returns spr_rdata at that pointer. A write to register 4 raises spr_we with the byte on spr_wdata. Both post-increment the pointer modulo 256.
- R10: Reads of registers 0, 1, 3, 5 and 6 return the data-register buffer and change no state.
- R11: Synchronous reset clears the toggle, the temporary and current addresses, the buffer, the control and mask bytes and the sprite pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, valid in the cycle of cpu_rd |
| stat_in | input | 8 | Status byte supplied by the rendering side |
| vram_addr | output | 14 | Video memory address |
| vram_rd | output | 1 | Video memory fetch request, data expected next cycle |
| vram_wr | output | 1 | Video memory write strobe |
| vram_wdata | output | 8 | Video memory write data |
| vram_rdata | input | 8 | Video memory read data, one cycle after vram_rd |
| spr_addr | output | 8 | Sprite memory pointer |
| spr_we | output | 1 | Sprite memory write strobe |
| spr_wdata | output | 8 | Sprite memory write data |
| spr_rdata | input | 8 | Sprite memory read data at spr_addr, combinational |
| ctrl_o | output | 8 | Stored control byte |
| mask_o | output | 8 | Stored mask byte |
| tmp_addr_o | output | 15 | Temporary video address |
| cur_addr_o | output | 15 | Current video address |

## Verification
The assertions assume a CPU access never raises cpu_rd and cpu_wr together, and that no data-register access lands in the cycle right after a data-register read, while the refill is still in flight. The bench drives each access as a single strobed cycle followed by one idle cycle, which meets both assumptions, and it draws window addresses across all mirrors as well as addresses outside the window. Its video memory returns a byte computed from the fetch address one cycle after the request, so the bench model can predict every buffered read.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

    localparam int DATA_W       = 8;
    localparam int VRAM_AW      = 14;
    localparam int TADDR_W      = 15;
    localparam int SPR_AW       = 8;
    localparam int NUM_REGS     = 8;
    localparam int SEL_W        = $clog2(NUM_REGS);
    localparam int CPU_AW       = 16;
    localparam int WIN_TAG_W    = 3;
    localparam int CTRL_INC_BIT = 2;
    localparam int STEP_WIDE    = 32;

    typedef enum logic [SEL_W-1:0] {
        REG_CTRL = 3'd0,
        REG_MASK = 3'd1,
        REG_STAT = 3'd2,
        REG_SPRA = 3'd3,
        REG_SPRD = 3'd4,
        REG_SCRL = 3'd5,
        REG_ADDR = 3'd6,
        REG_DATA = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_REGS-1:0] rd;
        logic [NUM_REGS-1:0] wr;
    } reg_stb_t;

    function automatic logic [TADDR_W-1:0] addr_step(input logic [DATA_W-1:0] ctrl);
        return ctrl[CTRL_INC_BIT] ? TADDR_W'(STEP_WIDE) : TADDR_W'(1);
    endfunction

endpackage

// File: rtl/vcr_decode.sv
module vcr_decode
    import vcr_pkg::*;
#(
    parameter logic [WIN_TAG_W-1:0] WIN_TAG = 3'b001
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic              in_win,
    output reg_stb_t          stb
);

    logic [SEL_W-1:0]    idx;
    logic [NUM_REGS-1:0] rd_v;
    logic [NUM_REGS-1:0] wr_v;

    assign in_win = (cpu_addr[CPU_AW-1 -: WIN_TAG_W] == WIN_TAG);
    assign idx    = cpu_addr[SEL_W-1:0];

    // read takes priority when both strobes are raised
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign rd_v[g] = in_win & cpu_rd & (idx == SEL_W'(g));
        assign wr_v[g] = in_win & cpu_wr & ~cpu_rd & (idx == SEL_W'(g));
    end

    assign stb.rd = rd_v;
    assign stb.wr = wr_v;

endmodule

// File: rtl/vcr_addr_regs.sv
module vcr_addr_regs
    import vcr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ctrl,
    input  logic               wr_scrl,
    input  logic               wr_addr,
    input  logic               rd_stat,
    input  logic               advance,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  ctrl_q,
    output logic               toggle,
    output logic [TADDR_W-1:0] tmp_addr,
    output logic [TADDR_W-1:0] cur_addr,
    output logic [TADDR_W-1:0] step
);

    assign step = addr_step(ctrl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            toggle   <= 1'b0;
            tmp_addr <= '0;
            cur_addr <= '0;
        end else begin
            if (rd_stat)
                toggle <= 1'b0;
            else if (wr_scrl || wr_addr)
                toggle <= ~toggle;

            if (wr_ctrl)
                tmp_addr[11:10] <= wdata[1:0];

            if (wr_scrl && !toggle)
                tmp_addr[4:0] <= wdata[7:3];
            if (wr_scrl && toggle) begin
                tmp_addr[9:5]   <= wdata[7:3];
                tmp_addr[14:12] <= wdata[2:0];
            end

            if (wr_addr && !toggle) begin
                tmp_addr[14]   <= 1'b0;
                tmp_addr[13:8] <= wdata[5:0];
            end

            if (wr_addr && toggle) begin
                tmp_addr[7:0] <= wdata;
                cur_addr      <= {tmp_addr[14:8], wdata};
            end else if (advance) begin
                cur_addr <= cur_addr + step;
            end
        end
    end

    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_stat |=> !toggle);  // R6

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (rst)
        ((wr_scrl || wr_addr) && !rd_stat) |=> (toggle != $past(toggle)));  // R6

    AST_ADDR_COPY: assert property (@(posedge clk) disable iff (rst)
        (wr_addr && toggle) |=> (cur_addr == tmp_addr));  // R5

    AST_CTRL_TO_TMP: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (tmp_addr[11:10] == $past(wdata[1:0])));  // R2

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (advance && !wr_addr) |=> (cur_addr == $past(cur_addr) + $past(step)));  // R7

endmodule

// File: rtl/vcr_data_port.sv
module vcr_data_port
    import vcr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_req,
    input  logic               wr_req,
    input  logic [VRAM_AW-1:0] cur_lo,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic [DATA_W-1:0]  vram_rdata,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic               vram_rd,
    output logic               vram_wr,
    output logic [DATA_W-1:0]  vram_wdata,
    output logic [DATA_W-1:0]  rbuf,
    output logic               advance
);

    logic fill_pend;

    assign vram_addr  = cur_lo;
    assign vram_rd    = rd_req;
    assign vram_wr    = wr_req;
    assign vram_wdata = cpu_wdata;
    assign advance    = rd_req | wr_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_pend <= 1'b0;
            rbuf      <= '0;
        end else begin
            fill_pend <= rd_req;
            if (fill_pend)
                rbuf <= vram_rdata;
        end
    end

    AST_VRAM_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        !(vram_rd && vram_wr));  // R8

    AST_FILL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        vram_rd |=> ##1 (rbuf == $past(vram_rdata)));  // R7

endmodule

// File: rtl/vcr_sprite_port.sv
module vcr_sprite_port
    import vcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_base,
    input  logic              rd_data,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    output logic [SPR_AW-1:0] spr_addr,
    output logic              spr_we,
    output logic [DATA_W-1:0] spr_wdata
);

    assign spr_we    = wr_data;
    assign spr_wdata = wdata;

    always_ff @(posedge clk) begin
        if (rst)
            spr_addr <= '0;
        else if (wr_base)
            spr_addr <= wdata[SPR_AW-1:0];
        else if (rd_data || wr_data)
            spr_addr <= spr_addr + SPR_AW'(1);
    end

    AST_SPR_POSTINC: assert property (@(posedge clk) disable iff (rst)
        ((rd_data || wr_data) && !wr_base) |=> (spr_addr == $past(spr_addr) + SPR_AW'(1)));  // R9

    AST_SPR_BASE: assert property (@(posedge clk) disable iff (rst)
        wr_base |=> (spr_addr == $past(wdata[SPR_AW-1:0])));  // R9

endmodule

// File: rtl/vid_reg_port.sv
module vid_reg_port
    import vcr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic [DATA_W-1:0]  stat_in,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic               vram_rd,
    output logic               vram_wr,
    output logic [DATA_W-1:0]  vram_wdata,
    input  logic [DATA_W-1:0]  vram_rdata,
    output logic [SPR_AW-1:0]  spr_addr,
    output logic               spr_we,
    output logic [DATA_W-1:0]  spr_wdata,
    input  logic [DATA_W-1:0]  spr_rdata,
    output logic [DATA_W-1:0]  ctrl_o,
    output logic [DATA_W-1:0]  mask_o,
    output logic [TADDR_W-1:0] tmp_addr_o,
    output logic [TADDR_W-1:0] cur_addr_o
);

    logic               in_win;
    reg_stb_t           stb;
    logic               toggle;
    logic [TADDR_W-1:0] step;
    logic [DATA_W-1:0]  rbuf;
    logic               advance;

    vcr_decode u_dec (
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .in_win   (in_win),
        .stb      (stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
            mask_o <= '0;
        end else begin
            if (stb.wr[REG_CTRL]) ctrl_o <= cpu_wdata;
            if (stb.wr[REG_MASK]) mask_o <= cpu_wdata;
        end
    end

    vcr_addr_regs u_addr (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (stb.wr[REG_CTRL]),
        .wr_scrl  (stb.wr[REG_SCRL]),
        .wr_addr  (stb.wr[REG_ADDR]),
        .rd_stat  (stb.rd[REG_STAT]),
        .advance  (advance),
        .wdata    (cpu_wdata),
        .ctrl_q   (ctrl_o),
        .toggle   (toggle),
        .tmp_addr (tmp_addr_o),
        .cur_addr (cur_addr_o),
        .step     (step)
    );

    vcr_data_port u_data (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (stb.rd[REG_DATA]),
        .wr_req     (stb.wr[REG_DATA]),
        .cur_lo     (cur_addr_o[VRAM_AW-1:0]),
        .cpu_wdata  (cpu_wdata),
        .vram_rdata (vram_rdata),
        .vram_addr  (vram_addr),
        .vram_rd    (vram_rd),
        .vram_wr    (vram_wr),
        .vram_wdata (vram_wdata),
        .rbuf       (rbuf),
        .advance    (advance)
    );

    vcr_sprite_port u_spr (
        .clk       (clk),
        .rst       (rst),
        .wr_base   (stb.wr[REG_SPRA]),
        .rd_data   (stb.rd[REG_SPRD]),
        .wr_data   (stb.wr[REG_SPRD]),
        .wdata     (cpu_wdata),
        .spr_addr  (spr_addr),
        .spr_we    (spr_we),
        .spr_wdata (spr_wdata)
    );

    always_comb begin
        if (stb.rd[REG_STAT])
            cpu_rdata = stat_in;
        else if (stb.rd[REG_SPRD])
            cpu_rdata = spr_rdata;
        else if (|stb.rd)
            cpu_rdata = rbuf;
        else
            cpu_rdata = '0;
    end

    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_win |-> !(vram_rd || vram_wr || spr_we));  // R1

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (cur_addr_o == '0 && tmp_addr_o == '0 && !toggle && rbuf == '0));  // R11

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && in_win && cpu_addr[SEL_W-1:0] == REG_STAT) |-> (cpu_rdata == stat_in));  // R6

endmodule

// File: tb/vid_reg_port_test.sv
module vid_reg_port_test;
    import vcr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0, cpu_rdata, stat_in = '0;
    logic [13:0] vram_addr;
    logic        vram_rd, vram_wr;
    logic [7:0]  vram_wdata, vram_rdata;
    logic [7:0]  spr_addr, spr_wdata, spr_rdata;
    logic        spr_we;
    logic [7:0]  ctrl_o, mask_o;
    logic [14:0] tmp_addr_o, cur_addr_o;

    always #5 clk = ~clk;

    vid_reg_port uut (.*);

    function automatic logic [7:0] vmem(input logic [13:0] a);
        return (a[7:0] ^ {a[13:8], 2'b10}) + 8'h11;
    endfunction

    logic [7:0] vq = '0;
    always @(posedge clk) if (vram_rd) vq <= vmem(vram_addr);
    assign vram_rdata = vq;
    assign spr_rdata  = spr_addr ^ 8'hC3;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0]  m_ctrl, m_mask, m_buf, m_spr;
    logic [14:0] m_tmp, m_cur;
    bit          m_tog;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [14:0] m_step();
        return m_ctrl[2] ? 15'd32 : 15'd1;
    endfunction

    task automatic check_state(input string req);
        chk(req, "ctrl", ctrl_o, m_ctrl);
        chk(req, "mask", mask_o, m_mask);
        chk(req, "tmp", tmp_addr_o, m_tmp);
        chk(req, "cur", cur_addr_o, m_cur);
        chk(req, "spr_addr", spr_addr, m_spr);
    endtask

    task automatic acc(input bit wr, input logic [15:0] a, input logic [7:0] d);
        bit inw;
        string req;
        logic [7:0] exp_rd;
        bit ev_rd, ev_wr, es_we;
        logic [13:0] ev_addr;
        @(negedge clk);
        cpu_addr  = a;
        cpu_rd    = !wr;
        cpu_wr    = wr;
        cpu_wdata = d;
        stat_in   = 8'($urandom);
        #1;
        inw = (a[15:13] == 3'b001);
        exp_rd = 8'h00; ev_rd = 0; ev_wr = 0; es_we = 0; ev_addr = m_cur[13:0];
        req = "R1";
        if (inw && !wr) begin
            case (a[2:0])
                3'd2: begin req = "R6"; exp_rd = stat_in; m_tog = 0; end
                3'd4: begin req = "R9"; exp_rd = m_spr ^ 8'hC3; m_spr++; end
                3'd7: begin
                    req = "R7"; exp_rd = m_buf; ev_rd = 1;
                    m_buf = vmem(m_cur[13:0]); m_cur = m_cur + m_step();
                end
                default: begin req = "R10"; exp_rd = m_buf; end
            endcase
        end else if (inw && wr) begin
            case (a[2:0])
                3'd0: begin req = "R2"; m_ctrl = d; m_tmp[11:10] = d[1:0]; end
                3'd1: begin req = "R3"; m_mask = d; end
                3'd2: req = "R6";
                3'd3: begin req = "R9"; m_spr = d; end
                3'd4: begin
                    req = "R9"; es_we = 1;
                    chk(req, "spr_addr at write", spr_addr, m_spr);
                    chk(req, "spr_wdata", spr_wdata, d);
                    m_spr++;
                end
                3'd5: begin
                    req = "R4";
                    if (!m_tog) m_tmp[4:0] = d[7:3];
                    else begin m_tmp[9:5] = d[7:3]; m_tmp[14:12] = d[2:0]; end
                    m_tog = !m_tog;
                end
                3'd6: begin
                    req = "R5";
                    if (!m_tog) begin m_tmp[14] = 1'b0; m_tmp[13:8] = d[5:0]; end
                    else begin m_tmp[7:0] = d; m_cur = m_tmp; end
                    m_tog = !m_tog;
                end
                default: begin
                    req = "R8"; ev_wr = 1;
                    chk(req, "vram_wdata", vram_wdata, d);
                    m_cur = m_cur + m_step();
                end
            endcase
        end
        if (!wr) chk(req, "cpu_rdata", cpu_rdata, exp_rd);
        chk(req, "vram_rd", vram_rd, ev_rd);
        chk(req, "vram_wr", vram_wr, ev_wr);
        chk(req, "spr_we", spr_we, es_we);
        if (ev_rd || ev_wr) chk(req, "vram_addr", vram_addr, ev_addr);
        @(negedge clk);
        cpu_rd = 0;
        cpu_wr = 0;
        #1;
        check_state(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_ctrl = 0; m_mask = 0; m_buf = 0; m_spr = 0; m_tmp = 0; m_cur = 0; m_tog = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check_state("R11");
        acc(0, 16'h2000, 8'h00);                 // R11 buffer reads as zero (R10 path)

        // R2 step and nametable bits; R5 address load
        acc(1, 16'h2000, 8'h07);
        acc(1, 16'h2006, 8'hFF);                 // bit 14 cleared, 13:8 = 3F
        acc(1, 16'h2006, 8'hF0);
        chk("R5", "cur after load", cur_addr_o, 15'h3FF0);
        acc(0, 16'h2007, 8'h00);                 // R7 returns old buffer
        acc(0, 16'h2007, 8'h00);                 // R7 step 32 crosses 14-bit mask
        acc(0, 16'h3FFF, 8'h00);                 // R1 mirror of data register
        // R6 status read resets toggle mid-pair
        acc(1, 16'h2005, 8'hAB);
        acc(0, 16'h2002, 8'h00);
        acc(1, 16'h2005, 8'h5D);
        acc(1, 16'h3FFD, 8'hEF);
        // R6 status write ignored, toggle untouched
        acc(1, 16'h2006, 8'h12);
        acc(1, 16'h200A, 8'h55);
        acc(1, 16'h200E, 8'h34);
        // R9 sprite wrap
        acc(1, 16'h2003, 8'hFE);
        acc(1, 16'h2004, 8'h11);
        acc(0, 16'h2004, 8'h00);
        acc(0, 16'h2004, 8'h00);
        // R1 outside window
        acc(1, 16'h4007, 8'h99);
        acc(0, 16'h4007, 8'h00);
        acc(1, 16'h0000, 8'h88);
        // R3 mask, R8 writes with step 1
        acc(1, 16'h2001, 8'h1E);
        acc(1, 16'h2000, 8'h00);
        acc(1, 16'h2007, 8'h42);
        acc(1, 16'h2007, 8'h43);
        acc(0, 16'h2001, 8'h00);                 // R10

        for (int i = 0; i < 1500; i++) begin
            logic [15:0] a;
            if ($urandom_range(9) == 0)
                a = {3'($urandom_range(7) | 3'b010), 13'($urandom)};
            else
                a = {3'b001, 10'($urandom), 3'($urandom)};
            acc(1'($urandom), a, 8'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule